// File: doc/BRIEF.md
# Serial-Bus Configuration Register Slave

This block is a two-wire serial-bus slave that lets an external host read and write a bank of sixteen byte-wide configuration registers: gain, blue and red balance, saturation and a control register among them. SCL and SDA arrive asynchronously. They are resynchronised and filtered on the fast system clock, and the slave decodes every bus event on that clock. SDA is driven only through an output-enable that pulls the line low. All register contents are presented in parallel on `regs_o`, so the rest of the chip can use them directly.

A write transfer carries the device address, then a subaddress, then one or more data bytes. A read transfer carries no subaddress. It returns data starting from the pointer that earlier traffic left behind. Each data byte, read or written, advances that pointer. To aim a read at a chosen location, the host first sends an address-plus-subaddress write with no data. The bus interface stays dormant unless a strap input is high when reset is released. Setting bit 7 of the control register at subaddress 0x0F returns every register to its default. That bit then clears itself.

Top module: `cfg_i2c_slave`

## Requirements
- R1: The address byte 0x80 (write) and 0x81 (read) are acknowledged by pulling SDA low on the ninth clock. Any other address byte gets no acknowledge, and the rest of that transfer has no effect.
- R2: In a write, the first byte after the address loads the pointer and each later byte is stored at the pointer. The stored value appears on `regs_o[8*k +: 8]` for subaddress k.
- R3: A read sends bytes MSB first, starting at the current pointer, with no subaddress phase. A write made of address plus subaddress only sets the pointer for a later read.
- R4: Each data byte, read or written, advances the 8-bit pointer by one. The advanced value persists across STOP into the next transfer.
- R5: A START seen in the middle of a transfer aborts it and discards any partial byte. The slave then waits for a fresh address byte.
- R6: Writes to subaddresses 0x10 and above are acknowledged but change no register. Reads from those subaddresses return 0x00.
- R7: During a read, the slave releases SDA on the ninth clock of each byte. After a host NACK, SDA stays released until the next STOP or START. After a host ACK, the next byte follows.
- R8: SDA is only pulled low or released, never driven high. The output-enable changes only while SCL is low.
- R9: The strap is sampled once, on the first clock after reset release. If it is low, all bus traffic is ignored (no acknowledge, no register change) until the next reset, whatever the strap does later.
- R10: Writing a byte with bit 7 set to subaddress 0x0F returns every register to its default on the following clock. Bit 7 then reads back 0. The pointer is left as advanced by that byte.
- R11: Reset defaults are 0x20 at 0x00 (gain), 0x80 at 0x01, 0x02 and 0x03 (blue, red, saturation), and 0x00 elsewhere.
- R12: A pulse on SDA or SCL that lasts shorter than the filter length (3 system clocks) is not seen. In particular, a one-clock SDA dip while SCL is high does not abort a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_strap_i | input | 1 | Bus-enable strap, sampled after reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| regs_o | output | 128 | All sixteen registers, subaddress k at bits 8k+7..8k |

## Verification
The soft-reset clear and the pointer advance are both triggered by the same data byte. To provoke the overlap, the control byte is sent inside a burst that has just written another register. The bench then expects every register output back at its default, including the register written earlier in the same burst. It also expects a following read with no subaddress to return 0x00 from location 0x10, not the gain default that a cleared pointer would give. A separate test checks that a one-clock SDA dip inside a data bit is rejected by the filter and does not count as a START.

// File: rtl/cfg_i2c_pkg.sv
package cfg_i2c_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_ADDR,
    S_AACK_W,
    S_AACK_R,
    S_SUB,
    S_SACK,
    S_WDATA,
    S_DACK,
    S_RDATA,
    S_RACK,
    S_WAIT
  } bus_state_e;

  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned SRST_BIT = 7;

  // Power-up contents of each configuration location.
  function automatic logic [BYTE_W-1:0] reg_default(input int unsigned idx);
    case (idx)
      0:       reg_default = 8'h20;
      1, 2, 3: reg_default = 8'h80;
      default: reg_default = 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/cfg_i2c_sync.sv
module cfg_i2c_sync #(
  parameter int unsigned FILT = 3,
  localparam int unsigned CW  = $clog2(FILT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  logic          s1_q, s2_q, f_q, f_n;
  logic [CW-1:0] cnt_q, cnt_n;

  always_comb begin
    f_n   = f_q;
    cnt_n = '0;
    if (s2_q != f_q) begin
      if (cnt_q == CW'(FILT - 1)) f_n = s2_q;
      else                        cnt_n = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q  <= 1'b1;
      s2_q  <= 1'b1;
      f_q   <= 1'b1;
      cnt_q <= '0;
    end else begin
      s1_q  <= din;
      s2_q  <= s1_q;
      f_q   <= f_n;
      cnt_q <= cnt_n;
    end
  end

  assign dout = f_q;

endmodule

// File: rtl/cfg_i2c_frame.sv
module cfg_i2c_frame
  import cfg_i2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              scl,
  input  logic              sda,
  input  logic [BYTE_W-1:0] rd_data,
  output logic [BYTE_W-1:0] rd_addr,
  output logic              wr_en,
  output logic [BYTE_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              sda_oe
);

  localparam logic [BYTE_W-1:0] ADDR_WR = {DEV_ADDR, 1'b0};
  localparam logic [BYTE_W-1:0] ADDR_RD = {DEV_ADDR, 1'b1};

  bus_state_e        state_q, state_n;
  logic [3:0]        bcnt_q, bcnt_n;
  logic [BYTE_W-1:0] sh_q, sh_n, tx_q, tx_n, ptr_q, ptr_n;
  logic              oe_q, oe_n, ack_q, ack_n;
  logic              scl_q, sda_q;
  logic              scl_rise, scl_fall, start_det, stop_det, byte_end;

  assign scl_rise  = scl & ~scl_q;
  assign scl_fall  = ~scl & scl_q;
  assign start_det = scl & scl_q & sda_q & ~sda;
  assign stop_det  = scl & scl_q & ~sda_q & sda;
  assign byte_end  = scl_fall && (bcnt_q == 4'd8);

  always_comb begin
    state_n = state_q;
    bcnt_n  = bcnt_q;
    sh_n    = sh_q;
    tx_n    = tx_q;
    ptr_n   = ptr_q;
    oe_n    = oe_q;
    ack_n   = ack_q;
    wr_en   = 1'b0;
    if (!en) begin
      state_n = S_IDLE;
      bcnt_n  = '0;
      oe_n    = 1'b0;
    end else if (start_det) begin
      state_n = S_ADDR;
      bcnt_n  = '0;
      oe_n    = 1'b0;
    end else if (stop_det) begin
      state_n = S_IDLE;
      bcnt_n  = '0;
      oe_n    = 1'b0;
    end else begin
      case (state_q)
        S_ADDR, S_SUB, S_WDATA: begin
          if (scl_rise) begin
            sh_n   = {sh_q[BYTE_W-2:0], sda};
            bcnt_n = bcnt_q + 4'd1;
          end else if (byte_end) begin
            bcnt_n = '0;
            case (state_q)
              S_ADDR: begin
                if (sh_q == ADDR_WR) begin
                  state_n = S_AACK_W;
                  oe_n    = 1'b1;
                end else if (sh_q == ADDR_RD) begin
                  state_n = S_AACK_R;
                  oe_n    = 1'b1;
                end else begin
                  state_n = S_WAIT;
                end
              end
              S_SUB: begin
                ptr_n   = sh_q;
                state_n = S_SACK;
                oe_n    = 1'b1;
              end
              default: begin
                wr_en   = 1'b1;
                ptr_n   = ptr_q + 8'd1;
                state_n = S_DACK;
                oe_n    = 1'b1;
              end
            endcase
          end
        end
        S_AACK_W: begin
          if (scl_fall) begin
            oe_n    = 1'b0;
            state_n = S_SUB;
          end
        end
        S_SACK, S_DACK: begin
          if (scl_fall) begin
            oe_n    = 1'b0;
            state_n = S_WDATA;
          end
        end
        S_AACK_R: begin
          if (scl_fall) begin
            tx_n    = rd_data;
            oe_n    = ~rd_data[BYTE_W-1];
            bcnt_n  = '0;
            state_n = S_RDATA;
          end
        end
        S_RDATA: begin
          if (scl_rise) begin
            bcnt_n = bcnt_q + 4'd1;
          end else if (scl_fall) begin
            if (bcnt_q == 4'd8) begin
              oe_n    = 1'b0;
              bcnt_n  = '0;
              ptr_n   = ptr_q + 8'd1;
              state_n = S_RACK;
            end else begin
              tx_n = {tx_q[BYTE_W-2:0], 1'b0};
              oe_n = ~tx_q[BYTE_W-2];
            end
          end
        end
        S_RACK: begin
          if (scl_rise) begin
            ack_n = ~sda;
          end else if (scl_fall) begin
            if (ack_q) begin
              tx_n    = rd_data;
              oe_n    = ~rd_data[BYTE_W-1];
              state_n = S_RDATA;
            end else begin
              state_n = S_WAIT;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      bcnt_q  <= '0;
      sh_q    <= '0;
      tx_q    <= '0;
      ptr_q   <= '0;
      oe_q    <= 1'b0;
      ack_q   <= 1'b0;
      scl_q   <= 1'b1;
      sda_q   <= 1'b1;
    end else begin
      state_q <= state_n;
      bcnt_q  <= bcnt_n;
      sh_q    <= sh_n;
      tx_q    <= tx_n;
      ptr_q   <= ptr_n;
      oe_q    <= oe_n;
      ack_q   <= ack_n;
      scl_q   <= scl;
      sda_q   <= sda;
    end
  end

  assign rd_addr = ptr_q;
  assign wr_addr = ptr_q;
  assign wr_data = sh_q;
  assign sda_oe  = oe_q;

  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(oe_q) |-> !scl_q); // R8

  AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (ptr_q == $past(ptr_q) + 8'd1)); // R4

  AST_NACK_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_WAIT) |-> !oe_q); // R7

endmodule

// File: rtl/cfg_i2c_regbank.sv
module cfg_i2c_regbank
  import cfg_i2c_pkg::*;
#(
  parameter int unsigned NUM_REGS = 16,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS),
  localparam int unsigned CTRL    = NUM_REGS - 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [BYTE_W-1:0]          wr_addr,
  input  logic [BYTE_W-1:0]          wr_data,
  input  logic [BYTE_W-1:0]          rd_addr,
  output logic [BYTE_W-1:0]          rd_data,
  output logic [NUM_REGS*BYTE_W-1:0] regs_o
);

  logic [BYTE_W-1:0] regs_q [NUM_REGS];
  logic              srst_q, srst_n;

  assign srst_n = wr_en && (wr_addr == BYTE_W'(CTRL)) && wr_data[SRST_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) srst_q <= 1'b0;
    else        srst_q <= srst_n;
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic              we;
    logic              ld_def;
    logic [BYTE_W-1:0] nxt;
    assign we     = wr_en && (wr_addr == BYTE_W'(g));
    assign ld_def = srst_q;
    always_comb begin
      nxt = regs_q[g];
      if (ld_def)  nxt = reg_default(g);
      else if (we) nxt = wr_data;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            regs_q[g] <= reg_default(g);
      else if (ld_def || we) regs_q[g] <= nxt;
    end
    assign regs_o[g*BYTE_W +: BYTE_W] = regs_q[g];
  end

  assign rd_data = (rd_addr < BYTE_W'(NUM_REGS)) ? regs_q[rd_addr[IDX_W-1:0]] : '0;

  AST_SRST_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    srst_q |=> (!srst_q && !regs_o[CTRL*BYTE_W + SRST_BIT])); // R10

  AST_UNDEF_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr >= BYTE_W'(NUM_REGS)) && !srst_q) |=> $stable(regs_o)); // R6

endmodule

// File: rtl/cfg_i2c_slave.sv
module cfg_i2c_slave
  import cfg_i2c_pkg::*;
#(
  parameter int unsigned NUM_REGS = 16,
  parameter int unsigned FILT     = 3,
  parameter logic [6:0]  DEV_ADDR = 7'h40
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       en_strap_i,
  input  logic                       scl_i,
  input  logic                       sda_i,
  output logic                       sda_oe_o,
  output logic [NUM_REGS*BYTE_W-1:0] regs_o
);

  localparam int unsigned NLINES = 2;

  logic [1:0]        rst_sync_q;
  logic              rst_sn;
  logic              en_q, taken_q;
  logic [NLINES-1:0] raw, filt;
  logic              wr_en;
  logic [BYTE_W-1:0] wr_addr, wr_data, rd_addr, rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sn = rst_sync_q[1];

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      en_q    <= 1'b0;
      taken_q <= 1'b0;
    end else if (!taken_q) begin
      en_q    <= en_strap_i;
      taken_q <= 1'b1;
    end
  end

  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    cfg_i2c_sync #(.FILT(FILT)) u_sync (
      .clk  (clk),
      .rst_n(rst_sn),
      .din  (raw[g]),
      .dout (filt[g])
    );
  end

  cfg_i2c_frame #(.DEV_ADDR(DEV_ADDR)) u_frame (
    .clk    (clk),
    .rst_n  (rst_sn),
    .en     (en_q),
    .scl    (filt[1]),
    .sda    (filt[0]),
    .rd_data(rd_data),
    .rd_addr(rd_addr),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .sda_oe (sda_oe_o)
  );

  cfg_i2c_regbank #(.NUM_REGS(NUM_REGS)) u_regs (
    .clk    (clk),
    .rst_n  (rst_sn),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .rd_addr(rd_addr),
    .rd_data(rd_data),
    .regs_o (regs_o)
  );

  AST_OFF_IS_SILENT: assert property (@(posedge clk) disable iff (!rst_sn)
    !en_q |-> (!sda_oe_o && !wr_en)); // R9

endmodule

// File: tb/cfg_i2c_slave_tb.sv
module cfg_i2c_slave_tb;

  localparam int CLK_PERIOD = 10;
  localparam int QTR        = 20;
  localparam int WDOG       = 190000;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         en_strap;
  logic         scl;
  logic         host_sda;
  logic         sda_oe;
  logic [127:0] regs;
  logic         sda_bus;
  int           n_chk = 0;
  int           n_err = 0;
  int           oe_viol = 0;
  logic         oe_prev = 1'b0;

  assign sda_bus = host_sda & ~sda_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_i2c_slave u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_strap_i(en_strap),
    .scl_i     (scl),
    .sda_i     (sda_bus),
    .sda_oe_o  (sda_oe),
    .regs_o    (regs)
  );

  // Output-enable may only move while SCL is low (R8).
  always @(negedge clk) begin
    if (rst_n && (sda_oe != oe_prev) && scl) oe_viol++;
    oe_prev = sda_oe;
  end

  function automatic logic [7:0] rg(input int i);
    return regs[i*8 +: 8];
  endfunction

  function automatic logic [7:0] dflt(input int i);
    return (i == 0) ? 8'h20 : ((i >= 1 && i <= 3) ? 8'h80 : 8'h00);
  endfunction

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic strap);
    rst_n = 1'b0; en_strap = strap; scl = 1'b1; host_sda = 1'b1;
    w(5);
    rst_n = 1'b1;
    w(10);
  endtask

  task automatic bus_start();
    host_sda = 1'b0; w(QTR); scl = 1'b0; w(QTR);
  endtask

  task automatic bus_rstart();
    host_sda = 1'b1; w(QTR); scl = 1'b1; w(QTR); host_sda = 1'b0; w(QTR); scl = 1'b0; w(QTR);
  endtask

  task automatic bus_stop();
    host_sda = 1'b0; w(QTR); scl = 1'b1; w(QTR); host_sda = 1'b1; w(QTR);
  endtask

  task automatic send_bit(input logic b, input logic glitch);
    host_sda = b; w(QTR); scl = 1'b1;
    if (glitch) begin
      w(QTR/2); host_sda = 1'b0; w(1); host_sda = 1'b1; w(2*QTR - QTR/2 - 1);
    end else begin
      w(2*QTR);
    end
    scl = 1'b0; w(QTR);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i], 1'b0);
    host_sda = 1'b1; w(QTR); scl = 1'b1; w(QTR);
    ack = (sda_bus == 1'b0);
    w(QTR); scl = 1'b0; w(QTR);
  endtask

  task automatic recv_byte(input logic host_ack, output logic [7:0] d);
    host_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      w(QTR); scl = 1'b1; w(QTR); d[i] = sda_bus; w(QTR); scl = 1'b0;
    end
    w(QTR); host_sda = host_ack ? 1'b0 : 1'b1; w(QTR);
    scl = 1'b1; w(2*QTR); scl = 1'b0; w(QTR); host_sda = 1'b1;
  endtask

  task automatic set_ptr(input logic [7:0] sub);
    logic a;
    bus_start(); send_byte(8'h80, a); send_byte(sub, a); bus_stop();
  endtask

  task automatic t_reset();
    do_reset(1'b1);
    for (int i = 0; i < 16; i++) chk(rg(i) == dflt(i), "R11 default", rg(i), dflt(i));
    chk(sda_oe == 1'b0, "R8 idle release", sda_oe, 0);
  endtask

  task automatic t_write_single();
    logic a0, a1, a2;
    bus_start(); send_byte(8'h80, a0); send_byte(8'h00, a1); send_byte(8'h99, a2); bus_stop();
    chk(a0 && a1 && a2, "R1 write acks", {a0, a1, a2}, 3'b111);
    chk(rg(0) == 8'h99, "R2 single write", rg(0), 8'h99);
  endtask

  task automatic t_burst_write();
    logic a;
    logic [7:0] v;
    bus_start(); send_byte(8'h80, a); send_byte(8'h08, a);
    for (int i = 0; i < 4; i++) begin
      v = 8'(8'h11 * (i + 1));
      send_byte(v, a);
    end
    bus_stop();
    for (int i = 0; i < 4; i++)
      chk(rg(8 + i) == 8'(8'h11 * (i + 1)), "R4 burst write", rg(8 + i), 8'(8'h11 * (i + 1)));
  endtask

  task automatic t_read_burst();
    logic a;
    logic quiet;
    logic [7:0] d;
    set_ptr(8'h08);
    bus_start(); send_byte(8'h81, a);
    chk(a, "R1 read address ack", a, 1);
    recv_byte(1'b1, d); chk(d == 8'h11, "R3 first read byte", d, 8'h11);
    recv_byte(1'b1, d); chk(d == 8'h22, "R4 read increment", d, 8'h22);
    recv_byte(1'b0, d); chk(d == 8'h33, "R7 byte before nack", d, 8'h33);
    quiet = 1'b1;
    for (int i = 0; i < 9; i++) begin
      w(QTR); scl = 1'b1; w(QTR); if (sda_bus !== 1'b1) quiet = 1'b0; w(QTR); scl = 1'b0;
    end
    w(QTR);
    chk(quiet, "R7 released after nack", quiet, 1);
    bus_stop();
    bus_start(); send_byte(8'h81, a); recv_byte(1'b0, d); bus_stop();
    chk(d == 8'h44, "R4 pointer kept across stop", d, 8'h44);
  endtask

  task automatic t_bad_addr();
    logic a0, a1, a2;
    bus_start(); send_byte(8'h90, a0); send_byte(8'h00, a1); send_byte(8'h12, a2); bus_stop();
    chk(!a0, "R1 foreign address nack", a0, 0);
    chk(!a1 && !a2, "R1 no ack after foreign address", {a1, a2}, 0);
    chk(rg(0) == 8'h99, "R1 foreign transfer no effect", rg(0), 8'h99);
  endtask

  task automatic t_undef();
    logic [127:0] snap;
    logic a;
    logic [7:0] d;
    snap = regs;
    bus_start(); send_byte(8'h80, a); send_byte(8'h10, a); send_byte(8'h77, a); bus_stop();
    chk(a, "R6 undefined write acked", a, 1);
    chk(regs == snap, "R6 undefined write dropped", regs[31:0], snap[31:0]);
    set_ptr(8'h10);
    bus_start(); send_byte(8'h81, a); recv_byte(1'b0, d); bus_stop();
    chk(d == 8'h00, "R6 undefined read zero", d, 0);
  endtask

  task automatic t_abort();
    logic a;
    bus_start(); send_byte(8'h80, a); send_byte(8'h04, a);
    for (int i = 0; i < 4; i++) send_bit(1'b1, 1'b0);
    bus_rstart();
    send_byte(8'h80, a);
    chk(a, "R5 fresh address after abort", a, 1);
    send_byte(8'h05, a); send_byte(8'h3C, a); bus_stop();
    chk(rg(4) == 8'h00, "R5 partial byte discarded", rg(4), 0);
    chk(rg(5) == 8'h3C, "R5 write after abort", rg(5), 8'h3C);
  endtask

  task automatic t_glitch();
    logic a;
    bus_start(); send_byte(8'h80, a); send_byte(8'h06, a);
    send_bit(1'b1, 1'b1);
    for (int i = 6; i >= 0; i--) send_bit(i >= 4, 1'b0);
    host_sda = 1'b1; w(QTR); scl = 1'b1; w(QTR); a = (sda_bus == 1'b0); w(QTR); scl = 1'b0; w(QTR);
    bus_stop();
    chk(a, "R12 glitch ignored ack", a, 1);
    chk(rg(6) == 8'hF0, "R12 glitch ignored data", rg(6), 8'hF0);
  endtask

  task automatic t_srst();
    logic a;
    logic [7:0] d;
    logic ok;
    bus_start(); send_byte(8'h80, a); send_byte(8'h0E, a); send_byte(8'h5A, a); send_byte(8'h80, a); bus_stop();
    ok = 1'b1;
    for (int i = 0; i < 16; i++) if (rg(i) != dflt(i)) ok = 1'b0;
    chk(ok, "R10 all defaults after soft reset", rg(14), 0);
    chk(rg(0) == 8'h20 && rg(15) == 8'h00, "R10 gain restored, bit cleared", {rg(0), rg(15)}, 16'h2000);
    bus_start(); send_byte(8'h81, a); recv_byte(1'b0, d); bus_stop();
    chk(d == 8'h00, "R10 pointer kept by soft reset", d, 0);
  endtask

  task automatic t_strap();
    logic a;
    do_reset(1'b0);
    bus_start(); send_byte(8'h80, a); bus_stop();
    chk(!a, "R9 strap low nack", a, 0);
    bus_start(); send_byte(8'h80, a); send_byte(8'h00, a); send_byte(8'h55, a); bus_stop();
    chk(rg(0) == 8'h20, "R9 strap low no write", rg(0), 8'h20);
    en_strap = 1'b1; w(5);
    bus_start(); send_byte(8'h80, a); bus_stop();
    chk(!a, "R9 late strap ignored", a, 0);
    do_reset(1'b1);
    en_strap = 1'b0; w(5);
    bus_start(); send_byte(8'h80, a); send_byte(8'h00, a); send_byte(8'h55, a); bus_stop();
    chk(rg(0) == 8'h55, "R9 enabled after strap high", rg(0), 8'h55);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual %0d expected <%0d", WDOG, WDOG);
    finish_run();
  end

  initial begin
    t_reset();
    t_write_single();
    t_burst_write();
    t_read_burst();
    t_bad_addr();
    t_undef();
    t_abort();
    t_glitch();
    t_srst();
    t_strap();
    chk(oe_viol == 0, "R8 enable moved with SCL high", oe_viol, 0);
    finish_run();
  end

endmodule